// File: doc/BRIEF.md
# Priority Grant-Chain Bus Arbiter

This block decides which of several devices may drive a shared bus. Every device raises its own request, and the arbiter sees only their OR, as if all of them pulled one shared line. So the arbiter knows that someone wants the bus but not who. When the bus is free, the arbiter issues a single grant token for one cycle. The token enters the chain at device 0 and moves down the chain one stage at a time. A stage that is requesting keeps the token and becomes the bus owner. A stage that is not requesting passes the token on at once, through combinational logic. Device 0 therefore always wins, and the last device wins only when no other device is asking.

The owner keeps the bus until it pulses the shared release line. After a release, the arbiter spends one idle cycle before it offers the token again. The block reports the owner as a one-hot grant vector and as a binary index with a valid flag. It also keeps one saturating counter per device, which counts the grant decisions that device lost while it was requesting. These counters make starvation of low-priority devices visible.

Top module: `chain_bus_arbiter`

## Requirements
- R1: After reset no grant is asserted, `owner_valid` is 0 and every starvation counter reads 0.
- R2: When any request is high while the arbiter is idle, a grant appears after the second rising clock edge and not after the first.
- R3: The requesting device with the lowest index wins the grant (device 0 has the highest priority).
- R4: At most one bit of `dev_grant` is ever high.
- R5: Once a device holds the grant, it keeps it until `bus_release` is sampled high, even if its own or any other request changes.
- R6: When `bus_release` is sampled high during ownership, the grant drops at that edge. The next grant appears no earlier than the second edge after that, which leaves at least one clock cycle with no grant.
- R7: `bus_release` is ignored while no device owns the bus, and a later request is granted with the normal timing.
- R8: While a grant is held, `owner_id` holds the binary index of the granted device and `owner_valid` is 1.
- R9: At each grant decision, the starvation counter of every device that is requesting but does not win goes up by 1. The winner's counter is cleared to 0. Counters of devices that are not requesting are unchanged. Each counter occupies bits [i*CNT_W +: CNT_W] of `starve_cnt` and stops at 2^CNT_W-1.
- R10: If every request is withdrawn in the cycle the token is offered, no device becomes owner, the arbiter returns to idle, and a later request is granted normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_req | input | N_DEV | Per-device bus request, bit 0 has the highest priority |
| bus_release | input | 1 | Owner's pulse that hands the bus back |
| dev_grant | output | N_DEV | One-hot local grant to the current owner |
| owner_valid | output | 1 | High while some device owns the bus |
| owner_id | output | $clog2(N_DEV) | Binary index of the owner |
| starve_cnt | output | N_DEV*CNT_W | Packed per-device counters of lost grant decisions |

## Verification
A stage that loses its ownership bit shows up within one cycle as `owner_valid` falling without a release. A wrongly set bit shows up as two grant bits or a wrong `owner_id`. A fault in the token ripple shows up at the very next grant decision: the wrong device wins, or no device wins while `owner_valid` stays low. A wrong arbiter state moves the grant one edge early or late, or removes the idle gap after a release. The starvation counters disagree with an independent model at the first grant decision after the fault.

// File: rtl/chain_arb_pkg.sv
package chain_arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OFFER = 2'd1,
    ST_HOLD  = 2'd2
  } arb_state_t;
endpackage

// File: rtl/chain_arb_fsm.sv
module chain_arb_fsm
  import chain_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_any,
  input  logic       token_lost,
  input  logic       bus_release,
  output logic       offer,
  output logic       drop,
  output arb_state_t state_o
);
  arb_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_any) state_d = ST_OFFER;
      ST_OFFER: state_d = token_lost ? ST_IDLE : ST_HOLD;
      ST_HOLD:  if (bus_release) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign offer   = (state_q == ST_OFFER);
  assign drop    = (state_q == ST_HOLD) && bus_release;
  assign state_o = state_q;

  // R2: an idle arbiter seeing a request offers the token next cycle
  assert_idle_to_offer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) && req_any |=> (state_q == ST_OFFER));
  // R6: release during hold returns to idle, so there is one idle cycle
  assert_release_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD) && bus_release |=> (state_q == ST_IDLE));
  // R7: a release outside hold does not move the arbiter into hold
  assert_idle_release_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |=> (state_q != ST_HOLD));
endmodule

// File: rtl/chain_stage.sv
module chain_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic tok_in,
  input  logic req,
  input  logic offer,
  input  logic drop,
  output logic tok_out,
  output logic take,
  output logic own
);
  logic own_q;

  assign take    = offer && tok_in && req;
  assign tok_out = tok_in && !req;

  always_ff @(posedge clk) begin
    if (!rst_n)    own_q <= 1'b0;
    else if (drop) own_q <= 1'b0;
    else if (take) own_q <= 1'b1;
  end

  assign own = own_q;

  // R5: ownership persists until the release is accepted
  assert_hold_until_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    own_q && !drop |=> own_q);
  // R3: a stage that captures the token owns the bus next cycle
  assert_take_owns_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> own_q);
endmodule

// File: rtl/starve_monitor.sv
module starve_monitor #(
  parameter int N_DEV = 4,
  parameter int CNT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               offer,
  input  logic [N_DEV-1:0]   req,
  input  logic [N_DEV-1:0]   take,
  output logic [N_DEV*CNT_W-1:0] cnt_flat
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  for (genvar i = 0; i < N_DEV; i++) begin : g_cnt
    logic [CNT_W-1:0] cnt_q;
    logic             lost;
    assign lost = offer && req[i] && !take[i];

    always_ff @(posedge clk) begin
      if (!rst_n)                cnt_q <= '0;
      else if (offer && take[i]) cnt_q <= '0;
      else if (lost)             cnt_q <= sat_inc(cnt_q);
    end

    assign cnt_flat[i*CNT_W +: CNT_W] = cnt_q;

    // R9: a lost decision below saturation adds exactly one
    assert_starve_inc_R9: assert property (@(posedge clk) disable iff (!rst_n)
      lost && (cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
    // R9: the winner's counter is cleared
    assert_starve_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      offer && take[i] |=> (cnt_q == '0));
  end
endmodule

// File: rtl/chain_bus_arbiter.sv
module chain_bus_arbiter
  import chain_arb_pkg::*;
#(
  parameter int N_DEV = 4,
  parameter int CNT_W = 8,
  localparam int IDW = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_DEV-1:0]       dev_req,
  input  logic                   bus_release,
  output logic [N_DEV-1:0]       dev_grant,
  output logic                   owner_valid,
  output logic [IDW-1:0]         owner_id,
  output logic [N_DEV*CNT_W-1:0] starve_cnt
);
  function automatic logic [IDW-1:0] onehot_index(input logic [N_DEV-1:0] v);
    logic [IDW-1:0] idx;
    idx = '0;
    for (int k = 0; k < N_DEV; k++) if (v[k]) idx = idx | IDW'(k);
    return idx;
  endfunction

  logic             req_any;
  logic             offer;
  logic             drop;
  logic             token_lost;
  arb_state_t       arb_state;
  logic [N_DEV:0]   tok_chain;
  logic [N_DEV-1:0] take_vec;
  logic [N_DEV-1:0] own_vec;

  assign req_any = |dev_req;

  chain_arb_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_any     (req_any),
    .token_lost  (token_lost),
    .bus_release (bus_release),
    .offer       (offer),
    .drop        (drop),
    .state_o     (arb_state)
  );

  assign tok_chain[0] = offer;
  for (genvar i = 0; i < N_DEV; i++) begin : g_stage
    chain_stage u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .tok_in  (tok_chain[i]),
      .req     (dev_req[i]),
      .offer   (offer),
      .drop    (drop),
      .tok_out (tok_chain[i+1]),
      .take    (take_vec[i]),
      .own     (own_vec[i])
    );
  end
  assign token_lost = tok_chain[N_DEV];

  starve_monitor #(.N_DEV(N_DEV), .CNT_W(CNT_W)) u_mon (
    .clk      (clk),
    .rst_n    (rst_n),
    .offer    (offer),
    .req      (dev_req),
    .take     (take_vec),
    .cnt_flat (starve_cnt)
  );

  assign dev_grant   = own_vec;
  assign owner_valid = |own_vec;
  assign owner_id    = onehot_index(own_vec);

  // R4: never two owners
  assert_single_owner_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(own_vec));
  // R6: after a grant is released there is at least one cycle without owner
  assert_gap_after_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(owner_valid) |=> !owner_valid);
  // R8: ownership only exists while the arbiter is holding
  assert_owner_in_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    owner_valid |-> (arb_state == ST_HOLD));
  // R10: a token that ran off the chain leaves no owner
  assert_lost_no_owner_R10: assert property (@(posedge clk) disable iff (!rst_n)
    offer && token_lost |=> !owner_valid);
endmodule

// File: tb/test_chain_bus_arbiter.sv
module test_chain_bus_arbiter;
  localparam int N = 4;
  localparam int W = 8;
  localparam int IDW = $clog2(N);
  localparam int CMAX = (1 << W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [N-1:0]     dev_req = '0;
  logic             bus_release = 1'b0;
  logic [N-1:0]     dev_grant;
  logic             owner_valid;
  logic [IDW-1:0]   owner_id;
  logic [N*W-1:0]   starve_cnt;

  int checks = 0;
  int failures = 0;
  int exp_starve [N];
  bit done = 0;

  always #10 clk = ~clk;

  chain_bus_arbiter #(.N_DEV(N), .CNT_W(W)) i_chain_bus_arbiter (
    .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .bus_release(bus_release),
    .dev_grant(dev_grant), .owner_valid(owner_valid), .owner_id(owner_id),
    .starve_cnt(starve_cnt)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int first_set(input logic [N-1:0] m);
    for (int k = N - 1; k >= 0; k--) ;
    for (int k = 0; k < N; k++) if (m[k]) return k;
    return -1;
  endfunction

  task automatic model_decision(input logic [N-1:0] m);
    int w;
    w = first_set(m);
    for (int k = 0; k < N; k++) begin
      if (k == w) exp_starve[k] = 0;
      else if (m[k] && exp_starve[k] < CMAX) exp_starve[k]++;
    end
  endtask

  task automatic check_counters(input string tag);
    for (int k = 0; k < N; k++)
      check(tag, int'(starve_cnt[k*W +: W]), exp_starve[k]);
  endtask

  // Full round from idle: request, grant, check, release.
  task automatic do_round(input logic [N-1:0] m, input bit full_check);
    int w;
    w = first_set(m);
    dev_req = m;
    tick();
    if (full_check) check("R2 no grant after first edge", int'(dev_grant), 0);
    tick();
    model_decision(m);
    if (full_check) begin
      check("R3 winner", int'(dev_grant), 1 << w);
      check("R8 owner_id", int'(owner_id), w);
      check("R8 owner_valid", int'(owner_valid), 1);
      check_counters("R9 counters");
    end
    dev_req = '0;
    bus_release = 1'b1;
    tick();
    bus_release = 1'b0;
    if (full_check) check("R6 grant dropped on release", int'(owner_valid), 0);
  endtask

  task automatic t_reset();
    check("R1 grant after reset", int'(dev_grant), 0);
    check("R1 owner_valid after reset", int'(owner_valid), 0);
    check("R1 counters after reset", int'(starve_cnt), 0);
  endtask

  task automatic t_priority();
    do_round(4'b1000, 1);
    do_round(4'b0110, 1);
    do_round(4'b1111, 1);
    do_round(4'b1100, 1);
    do_round(4'b0101, 1);
  endtask

  task automatic t_hold();
    dev_req = 4'b0100;
    tick(); tick();
    model_decision(4'b0100);
    check("R5 initial owner", int'(dev_grant), 4'b0100);
    dev_req = 4'b0001;
    tick(); tick(); tick();
    check("R5 held against higher request", int'(dev_grant), 4'b0100);
    check("R4 single grant", $countones(dev_grant), 1);
    dev_req = 4'b0000;
    tick();
    check("R5 held after own request drops", int'(dev_grant), 4'b0100);
    dev_req = 4'b0001;
    bus_release = 1'b1;
    tick();
    bus_release = 1'b0;
    check("R6 grant drops at release edge", int'(owner_valid), 0);
    tick();
    check("R6 idle gap cycle", int'(owner_valid), 0);
    tick();
    model_decision(4'b0001);
    check("R6 regrant after gap", int'(dev_grant), 4'b0001);
    check_counters("R9 counters after hold");
    dev_req = '0;
    bus_release = 1'b1;
    tick();
    bus_release = 1'b0;
  endtask

  task automatic t_release_idle();
    bus_release = 1'b1;
    tick(); tick();
    bus_release = 1'b0;
    check("R7 no owner from idle release", int'(owner_valid), 0);
    do_round(4'b0010, 1);
    dev_req = 4'b0100;
    tick();
    tick();
    model_decision(4'b0100);
    bus_release = 1'b1;
    tick();
    bus_release = 1'b0;
    check("R7 stray release ends only the real hold", int'(owner_valid), 0);
    dev_req = '0;
    tick();
  endtask

  task automatic t_withdraw();
    dev_req = 4'b0010;
    tick();
    dev_req = 4'b0000;
    tick();
    check("R10 no owner after withdraw", int'(owner_valid), 0);
    tick();
    check("R10 still no owner", int'(dev_grant), 0);
    check_counters("R10 counters unchanged");
    do_round(4'b1010, 1);
  endtask

  task automatic t_saturate();
    for (int r = 0; r < 260; r++) do_round(4'b1001, 0);
    check("R9 saturated counter dev3", int'(starve_cnt[3*W +: W]), CMAX);
    check("R9 winner counter dev0", int'(starve_cnt[0 +: W]), 0);
    check_counters("R9 counters after saturation");
    do_round(4'b1000, 1);
    check("R9 cleared after win", int'(starve_cnt[3*W +: W]), 0);
  endtask

  initial begin
    for (int k = 0; k < N; k++) exp_starve[k] = 0;
    @(negedge clk);
    tick(); tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_priority();
    t_hold();
    t_release_idle();
    t_withdraw();
    t_saturate();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule